// File: doc/BRIEF.md
# SHA-256 Midstate Nonce Search Engine

The engine hunts for a single-block message whose SHA-256 digest starts with a chosen 16-bit value. The message has two parts: a fixed leading part and a 12-character nonce at its end. Software hashes the leading part ahead of time and loads the saved working state (the midstate), the round index at which to resume, and the 16 message words of the block with padding already in place. The nonce is made of two groups of base-64 digits. The first group is a fixed prefix for each instance. The second group is a counter that steps by one per candidate. A 64-entry character table turns every digit into a printable ASCII byte.

For each candidate, the engine places the 12 characters into three consecutive message words. It then runs the remaining compression rounds at one round per clock. Only the first state word is added to the first initial hash value, and the top half of that sum is compared with the target. The first candidate that matches is latched and held until the next start pulse. If the counter comes back round to its starting value with no match, the engine raises done instead.

Top module: `nsearch_top`

## Requirements
- R1: After reset, busy, done and match_valid are all low.
- R2: A start pulse captures the inputs. In the next cycle busy is high and match_valid and done are low.
- R3: Each 6-bit digit d maps to one character byte. d = 0 gives 0x2B and d = 1 gives 0x2F. d = 2 to 11 gives '0' to '9'. d = 12 to 37 gives 'A' to 'Z'. d = 38 to 63 gives 'a' to 'z'. Characters therefore rise in value as the digit rises.
- R4: The nonce digit string is the prefix digits followed by the counter digits, most significant digit first. The 12 characters go big-endian into message words NONCE_WORD to NONCE_WORD+2. The first character sits in bits 31:24 of word NONCE_WORD, and match_nonce bits 95:88 carry it too. The nonce bytes in block_words are ignored.
- R5: Compression resumes from the loaded midstate at round start_round and runs through round 63. Round t uses message word t, taken from the block for t < 16 and expanded from the block above that. Supported start rounds are 0 to 16.
- R6: A candidate passes when bits 31:16 of (final state word A + 0x6a09e667) equal the target.
- R7: Each candidate takes 66 − start_round cycles. The k-th candidate's result appears k·(66 − start_round) clock edges after the edge that samples start.
- R8: Candidates are visited in counter order, incrementing modulo 2^(6·CNT_DIGITS). The first passing one is reported.
- R9: While match_valid is high, busy stays low and match_nonce is stable. Both hold until the next start.
- R10: If the next counter value equals the captured starting value, done rises with busy and match_valid low. Done holds until start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a search |
| midstate | input | 256 | Saved working state A..H, A in bits 255:224 |
| block_words | input | 512 | Padded message block, word 0 in bits 511:480 |
| start_round | input | 6 | First round still to be computed |
| prefix_digits | input | 6·(12−CNT_DIGITS) | Fixed leading nonce digits |
| start_count | input | 6·CNT_DIGITS | Initial counter value |
| target | input | 16 | Required top 16 digest bits |
| busy | output | 1 | Search in progress |
| done | output | 1 | Counter space exhausted without a match |
| match_valid | output | 1 | A passing nonce is held |
| match_nonce | output | 96 | The 12 passing characters |

## Verification
The properties assume that start is a single-cycle pulse. They also assume it does not arrive in the first two cycles after reset release, while the internal reset is still being synchronised. The data inputs must stay still whenever busy is high, and start_round must not exceed 16 or the first nonce word index. The bench keeps to these rules: it changes inputs only while the engine is idle, and it waits several cycles after reset. It uses start rounds of 0, 4, 7 and 10 with the nonce in words 10 to 12, and computes every midstate with its own hash model.

// File: rtl/nsearch_pkg.sv
package nsearch_pkg;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_ROUND, S_CHECK} srch_state_e;

  localparam logic [31:0] HASH_A0 = 32'h6a09e667;

  localparam logic [31:0] RND_K [64] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
  };

  function automatic logic [31:0] ror32(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [31:0] big_s0(input logic [31:0] x);
    return ror32(x, 2) ^ ror32(x, 13) ^ ror32(x, 22);
  endfunction

  function automatic logic [31:0] big_s1(input logic [31:0] x);
    return ror32(x, 6) ^ ror32(x, 11) ^ ror32(x, 25);
  endfunction

  function automatic logic [31:0] sml_s0(input logic [31:0] x);
    return ror32(x, 7) ^ ror32(x, 18) ^ (x >> 3);
  endfunction

  function automatic logic [31:0] sml_s1(input logic [31:0] x);
    return ror32(x, 17) ^ ror32(x, 19) ^ (x >> 10);
  endfunction

endpackage

// File: rtl/nsearch_expand.sv
module nsearch_expand #(
  parameter int NDIG = 12
) (
  input  logic [6*NDIG-1:0] digits_i,
  output logic [8*NDIG-1:0] chars_o
);

  // Character table: 64 entries, 8 bits each, built once from the digit value
  function automatic logic [7:0] digit_char(input logic [5:0] d);
    logic [7:0] dv;
    dv = {2'b00, d};
    if (d < 6'd2)       return (d == 6'd0) ? 8'h2B : 8'h2F;
    else if (d < 6'd12) return 8'h30 + dv - 8'd2;
    else if (d < 6'd38) return 8'h41 + dv - 8'd12;
    else                return 8'h61 + dv - 8'd38;
  endfunction

  logic [7:0] char_tab [64];

  for (genvar e = 0; e < 64; e++) begin : g_tab
    assign char_tab[e] = digit_char(6'(e));
  end

  for (genvar l = 0; l < NDIG; l++) begin : g_lane
    assign chars_o[8*NDIG-1-8*l -: 8] = char_tab[digits_i[6*NDIG-1-6*l -: 6]];
  end

endmodule

// File: rtl/nsearch_sched.sv
module nsearch_sched
  import nsearch_pkg::*;
(
  input  logic [511:0] win_i,
  input  logic [5:0]   rnd_i,
  output logic [31:0]  w_o,
  output logic [511:0] win_o
);

  logic [31:0] slot [16];
  logic [31:0] w_new;
  logic        direct;

  for (genvar s = 0; s < 16; s++) begin : g_slot
    assign slot[s] = win_i[511-32*s -: 32];
  end

  assign direct = (rnd_i < 6'd16);
  assign w_new  = sml_s1(slot[14]) + slot[9] + sml_s0(slot[1]) + slot[0];
  assign w_o    = direct ? slot[rnd_i[3:0]] : w_new;
  assign win_o  = direct ? win_i : {win_i[479:0], w_new};

endmodule

// File: rtl/nsearch_round.sv
module nsearch_round
  import nsearch_pkg::*;
(
  input  logic [255:0] st_i,
  input  logic [31:0]  w_i,
  input  logic [31:0]  k_i,
  output logic [255:0] st_o
);

  logic [31:0] a, b, c, d, e, f, g, h;
  logic [31:0] t1, t2;

  assign {a, b, c, d, e, f, g, h} = st_i;
  assign t1   = h + big_s1(e) + ((e & f) ^ (~e & g)) + k_i + w_i;
  assign t2   = big_s0(a) + ((a & b) ^ (a & c) ^ (b & c));
  assign st_o = {t1 + t2, a, b, c, d + t1, e, f, g};

endmodule

// File: rtl/nsearch_top.sv
module nsearch_top
  import nsearch_pkg::*;
#(
  parameter int CNT_DIGITS = 6,
  parameter int NONCE_WORD = 10
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [255:0]                midstate,
  input  logic [511:0]                block_words,
  input  logic [5:0]                  start_round,
  input  logic [6*(12-CNT_DIGITS)-1:0] prefix_digits,
  input  logic [6*CNT_DIGITS-1:0]     start_count,
  input  logic [15:0]                 target,
  output logic                        busy,
  output logic                        done,
  output logic                        match_valid,
  output logic [95:0]                 match_nonce
);

  localparam int CW     = 6 * CNT_DIGITS;
  localparam int NCHARS = 12;
  localparam int NW_MSB = 511 - 32 * NONCE_WORD;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  srch_state_e  state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d, base_q, base_d, cnt_inc;
  logic [5:0]    rnd_q, rnd_d;
  logic [255:0]  st_q, st_d, st_nxt;
  logic [511:0]  win_q, win_d, win_sh, win_load;
  logic          mv_q, mv_d, done_q, done_d;
  logic [95:0]   nonce_q, nonce_d, chars;
  logic [31:0]   w_cur, a_sum;
  logic          hit, dp_en;

  nsearch_expand #(.NDIG(NCHARS)) u_expand (
    .digits_i ({prefix_digits, cnt_q}),
    .chars_o  (chars)
  );

  nsearch_sched u_sched (
    .win_i (win_q),
    .rnd_i (rnd_q),
    .w_o   (w_cur),
    .win_o (win_sh)
  );

  nsearch_round u_round (
    .st_i (st_q),
    .w_i  (w_cur),
    .k_i  (RND_K[rnd_q]),
    .st_o (st_nxt)
  );

  always_comb begin
    win_load = block_words;
    win_load[NW_MSB -: 96] = chars;
  end

  assign cnt_inc = cnt_q + 1'b1;
  assign a_sum   = st_q[255:224] + HASH_A0;
  assign hit     = (a_sum[31:16] == target);
  assign dp_en   = (state_q == S_SETUP) || (state_q == S_ROUND);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    base_d  = base_q;
    rnd_d   = rnd_q;
    st_d    = st_q;
    win_d   = win_q;
    mv_d    = mv_q;
    done_d  = done_q;
    nonce_d = nonce_q;
    if (start) begin
      cnt_d   = start_count;
      base_d  = start_count;
      mv_d    = 1'b0;
      done_d  = 1'b0;
      state_d = S_SETUP;
    end else begin
      case (state_q)
        S_SETUP: begin
          st_d    = midstate;
          win_d   = win_load;
          rnd_d   = start_round;
          state_d = S_ROUND;
        end
        S_ROUND: begin
          st_d  = st_nxt;
          win_d = win_sh;
          if (rnd_q == 6'd63) state_d = S_CHECK;
          else                rnd_d   = rnd_q + 6'd1;
        end
        S_CHECK: begin
          if (hit) begin
            mv_d    = 1'b1;
            nonce_d = chars;
            state_d = S_IDLE;
          end else if (cnt_inc == base_q) begin
            done_d  = 1'b1;
            state_d = S_IDLE;
          end else begin
            cnt_d   = cnt_inc;
            state_d = S_SETUP;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      base_q  <= '0;
      mv_q    <= 1'b0;
      done_q  <= 1'b0;
      nonce_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      base_q  <= base_d;
      mv_q    <= mv_d;
      done_q  <= done_d;
      nonce_q <= nonce_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rnd_q <= '0;
      st_q  <= '0;
      win_q <= '0;
    end else if (dp_en) begin
      rnd_q <= rnd_d;
      st_q  <= st_d;
      win_q <= win_d;
    end
  end

  assign busy        = (state_q != S_IDLE);
  assign done        = done_q;
  assign match_valid = mv_q;
  assign match_nonce = nonce_q;

endmodule

// File: rtl/nsearch_chk.sv
module nsearch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        match_valid,
  input logic [95:0] match_nonce
);

  function automatic logic char_ok(input logic [7:0] c);
    return (c == 8'h2B) || (c == 8'h2F) || (c >= 8'h30 && c <= 8'h39) ||
           (c >= 8'h41 && c <= 8'h5A) || (c >= 8'h61 && c <= 8'h7A);
  endfunction

  function automatic logic all_ok(input logic [95:0] n);
    logic r;
    r = 1'b1;
    for (int i = 0; i < 12; i++) r = r & char_ok(n[95-8*i -: 8]);
    return r;
  endfunction

  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !match_valid && !done));

  p_chars_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    match_valid |-> all_ok(match_nonce));

  p_rise_from_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_valid) |-> $past(busy));

  p_idle_on_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    match_valid |-> !busy);

  p_hold_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (match_valid && !start) |=> (match_valid && $stable(match_nonce)));

  p_done_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !match_valid));

  p_done_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

endmodule

bind nsearch_top nsearch_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .match_valid (match_valid),
  .match_nonce (match_nonce)
);

// File: tb/nsearch_top_tb_top.sv
`timescale 1ns/1ps
module nsearch_top_tb_top;

  localparam int CD = 1;
  localparam int PW = 6 * (12 - CD);
  localparam logic [255:0] IV = {32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
                                 32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};
  localparam logic [PW-1:0] PREFIX = 66'h2_9C4F_0E1A_B375_D862;
  // vector: start round, winning counter, steps back from it
  localparam logic [15:0] VEC [4] = '{
    {6'd0,  6'd45, 4'd3},
    {6'd7,  6'd1,  4'd3},
    {6'd10, 6'd20, 4'd0},
    {6'd4,  6'd63, 4'd5}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [255:0] midstate;
  logic [511:0] block_words;
  logic [5:0] start_round;
  logic [PW-1:0] prefix_digits;
  logic [6*CD-1:0] start_count;
  logic [15:0] target;
  logic busy, done, match_valid;
  logic [95:0] match_nonce;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] kt [64];

  always #4 clk = ~clk;

  nsearch_top #(.CNT_DIGITS(CD), .NONCE_WORD(10)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .midstate(midstate),
    .block_words(block_words), .start_round(start_round),
    .prefix_digits(prefix_digits), .start_count(start_count), .target(target),
    .busy(busy), .done(done), .match_valid(match_valid), .match_nonce(match_nonce)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    logic [63:0] t;
    t = {x, x} >> n;
    return t[31:0];
  endfunction

  function automatic logic [255:0] run_rounds(input logic [255:0] s, input logic [511:0] blk,
                                              input int from, input int upto);
    logic [31:0] w [64];
    logic [31:0] a, b, c, d, e, f, g, h, t1, t2;
    for (int i = 0; i < 16; i++) w[i] = blk[511-32*i -: 32];
    for (int i = 16; i < 64; i++)
      w[i] = (rr(w[i-2], 17) ^ rr(w[i-2], 19) ^ (w[i-2] >> 10)) + w[i-7] +
             (rr(w[i-15], 7) ^ rr(w[i-15], 18) ^ (w[i-15] >> 3)) + w[i-16];
    {a, b, c, d, e, f, g, h} = s;
    for (int i = from; i < upto; i++) begin
      t1 = h + (rr(e, 6) ^ rr(e, 11) ^ rr(e, 25)) + ((e & f) | (~e & g)) + kt[i] + w[i];
      t2 = (rr(a, 2) ^ rr(a, 13) ^ rr(a, 22)) + ((a & b) | (c & (a | b)));
      h = g; g = f; f = e; e = d + t1; d = c; c = b; b = a; a = t1 + t2;
    end
    return {a, b, c, d, e, f, g, h};
  endfunction

  function automatic logic [95:0] ref_chars(input logic [PW-1:0] pre, input logic [5:0] cv);
    string al;
    logic [71:0] dg;
    logic [95:0] r;
    al = "+/0123456789ABCDEFGHIJKLMNOPQRSTUVWXYZabcdefghijklmnopqrstuvwxyz";
    dg = {pre, cv};
    for (int i = 0; i < 12; i++) r[95-8*i -: 8] = al[int'(dg[71-6*i -: 6])];
    return r;
  endfunction

  function automatic logic [511:0] make_blk(input logic [95:0] nc);
    logic [511:0] r;
    r = '0;
    for (int i = 0; i < 40; i++) r[511-8*i -: 8] = 8'h61 + 8'(i % 26);
    r[511-320 -: 96] = nc;
    r[511-416 -: 8] = 8'h80;
    r[15:0] = 16'h01A0;
    return r;
  endfunction

  function automatic logic [15:0] top16(input logic [5:0] cv);
    logic [255:0] s;
    logic [31:0] a;
    s = run_rounds(IV, make_blk(ref_chars(PREFIX, cv)), 0, 64);
    a = s[255:224] + IV[255:224];
    return a[31:16];
  endfunction

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // round constants from cube roots of the first 64 primes
    begin
      int p, cntp;
      p = 2; cntp = 0;
      while (cntp < 64) begin
        bit isp;
        isp = 1'b1;
        for (int q = 2; q * q <= p; q++) if (p % q == 0) isp = 1'b0;
        if (isp) begin
          logic [127:0] v, big;
          real r;
          r = $pow(real'(p), 1.0 / 3.0) * 4294967296.0;
          v = 128'(longint'(r));
          big = 128'(p) << 96;
          while (v * v * v > big) v = v - 1;
          while ((v + 1) * (v + 1) * (v + 1) <= big) v = v + 1;
          kt[cntp] = v[31:0];
          cntp++;
        end
        p++;
      end
    end

    begin
      logic [511:0] abc;
      logic [255:0] s;
      abc = '0;
      abc[511:480] = 32'h61626380;
      abc[31:0] = 32'h18;
      s = run_rounds(IV, abc, 0, 64);
      chk((s[255:224] + IV[255:224]) == 32'hba7816bf, "R5 model", s[255:224] + IV[255:224], 32'hba7816bf);
    end

    rst_n = 1'b0; start = 1'b0; midstate = '0; block_words = '0; start_round = '0;
    prefix_digits = PREFIX; start_count = '0; target = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(!busy && !done && !match_valid, "R1", {busy, done, match_valid}, 3'b000);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    chk(!busy && !done && !match_valid, "R1", {busy, done, match_valid}, 3'b000);

    block_words = make_blk(96'h0);
    for (int vi = 0; vi < 4; vi++) begin
      logic [5:0] rs, win, st0, first;
      logic [3:0] back;
      int kidx, cyc;
      {rs, win, back} = VEC[vi];
      st0 = win - 6'(back);
      target = top16(win);
      kidx = int'(back);
      for (int j = int'(back); j >= 0; j--)
        if (top16(st0 + 6'(j)) == target) kidx = j;
      first = st0 + 6'(kidx);
      start_round = rs;
      start_count = st0;
      midstate = run_rounds(IV, make_blk(96'h0), 0, int'(rs));
      pulse_start();
      chk(busy && !match_valid && !done, "R2", {busy, match_valid, done}, 3'b100);
      cyc = 0;
      while (!match_valid && !done && cyc < 5000) begin
        @(posedge clk);
        cyc++;
        #1;
      end
      chk(match_valid, "R6 match seen", match_valid, 1'b1);
      chk(cyc == (kidx + 1) * (66 - int'(rs)), "R7 cycles", cyc, (kidx + 1) * (66 - int'(rs)));
      chk(match_nonce == ref_chars(PREFIX, first), "R3 R4 R8 nonce", match_nonce, ref_chars(PREFIX, first));
      repeat (20) @(posedge clk);
      #1;
      chk(match_valid && !busy && match_nonce == ref_chars(PREFIX, first), "R9 hold",
          {match_valid, busy, match_nonce}, {2'b10, ref_chars(PREFIX, first)});
    end

    // exhaustion: a target no candidate reaches
    begin
      logic [15:0] tg;
      bit used;
      int cyc;
      tg = 16'h0000;
      used = 1'b1;
      while (used) begin
        used = 1'b0;
        for (int c = 0; c < 64; c++) if (top16(6'(c)) == tg) used = 1'b1;
        if (used) tg = tg + 16'd1;
      end
      target = tg;
      start_round = 6'd10;
      start_count = 6'd50;
      midstate = run_rounds(IV, make_blk(96'h0), 0, 10);
      pulse_start();
      chk(busy && !match_valid, "R2 restart", {busy, match_valid}, 2'b10);
      cyc = 0;
      while (!done && !match_valid && cyc < 8000) begin
        @(posedge clk);
        cyc++;
        #1;
      end
      chk(done && !match_valid, "R6 R10 no match", {done, match_valid}, 2'b10);
      chk(cyc == 64 * 56, "R10 wrap cycles", cyc, 64 * 56);
      repeat (10) @(posedge clk);
      #1;
      chk(done && !busy, "R10 hold", {done, busy}, 2'b10);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule